// File: doc/BRIEF.md
# Sixth-Order Single-Bit Resonator-Feedback Noise Shaper

This block turns an oversampled stream of signed PCM words into a one-bit density stream. A loop of six integrators shapes the quantization noise. The integrators form three resonator pairs in cascade, and each pair carries its own local feedback term. A one-bit quantizer closes the loop: it reads the sign of the last integrator and feeds plus or minus full scale back into every stage.

An upstream interpolator supplies a sample through `sampleValid`. A clock enable `ce` marks each modulator-rate tick, typically about 160 ticks per input sample for input rates from 44.1 kHz to 192 kHz. Every fractional coefficient is applied as a fixed sum of shifted copies of its operand, taken from the coefficient's canonical signed digit form, so no multiplier is needed. All terms that reach one integrator are added in a single balanced tree of at most eight operands, so each integrator input has at most three adder levels.

Top module: `sdm_crfb6`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), all six integrators and the held sample are zero, `bitOut` is 1 and `ovfFlag` is 0.
- R2: Integrators and `ovfFlag` change only at edges where `ce` is high. With `ce` low, `bitOut` and `ovfFlag` hold their values.
- R3: Only the top 24 bits of the `IN_W`-bit word are kept, as a two's complement value. The lower `IN_W`-24 bits have no effect on the output stream. Inside the loop, full scale is 2^(SW-1-HEAD), and the 24-bit value is scaled by 2^(SW-HEAD-24) (2^4 with the defaults).
- R4: `sampleValid` loads the held sample at its edge. An integrator update at the same edge still uses the previously held sample.
- R5: `bitOut` is 1 exactly when the last integrator is zero or positive. The loop treats 1 as +FS and 0 as -FS.
- R6: Every stage uses old states. Pair k holds stages 2k and 2k+1. Stage 2k gains its input, minus g_k times stage 2k+1, minus a_{2k} times the fed-back level. Stage 2k+1 gains stage 2k minus a_{2k+1} times the level. The input of pair 0 is the held sample times the input weight. The input of pairs 1 and 2 is stage 2k-1.
- R7: Each coefficient is an unsigned 32-bit fraction (value/2^32). A product with a state keeps the NG (g terms) or NB (input weight) most significant nonzero canonical-signed-digit digits. Each digit at bit position p adds or subtracts the operand arithmetically shifted right by 32-p. The feedback weight a_i enters as the constant ±floor(a_i·FS/2^32).
- R8: The default local feedback of the middle resonator is 0x16e4632b.
- R9: Each integrator's exact new sum is clamped to the signed SW-bit range instead of wrapping.
- R10: `ovfFlag` rises after the first update in which any integrator clamps. It then stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Modulator-rate update enable |
| sampleIn | input | IN_W | PCM word, MSB-aligned two's complement |
| sampleValid | input | 1 | Loads `sampleIn` into the held sample |
| bitOut | output | 1 | One-bit modulator output |
| ovfFlag | output | 1 | Sticky integrator clamp indicator |

## Verification
The assertions check on every cycle that the outputs freeze while `ce` is low, that the clamp flag never falls outside reset and rises only after an update, and that the outputs return to the reset state. The numeric behaviour can only be shown by the bench scenarios. These cover the exact bit pattern produced by the truncated signed-digit products, the old-sample ordering, the truncation of the low input bits, and saturation under a sustained full-scale input. The bench compares them against a fixed-point model built from the requirements.

// File: rtl/sdm_crfb6_pkg.sv
package sdm_crfb6_pkg;

  localparam int SAMPLE_W    = 24;
  localparam int ORDER       = 6;
  localparam int PAIRS       = ORDER / 2;
  localparam int COEF_W      = 32;
  localparam int TREE_LEVELS = 3;
  localparam int TREE_LEAVES = 1 << TREE_LEVELS;

  // strobes from control to datapath
  typedef struct packed {
    logic update;
    logic clear;
  } sdmStrobe_t;

  // one signed digit of a constant coefficient
  typedef struct packed {
    logic       en;
    logic       neg;
    logic [5:0] sh;
  } csdTerm_t;

  localparam logic [ORDER-1:0][COEF_W-1:0] DEF_FB = {
    32'h4000_0000, 32'h2000_0000, 32'h1000_0000,
    32'h0800_0000, 32'h0400_0000, 32'h4000_0000
  };
  localparam logic [COEF_W-1:0] DEF_IN = 32'h4000_0000;
  localparam logic [PAIRS-1:0][COEF_W-1:0] DEF_G = {
    32'h0040_0000, 32'h16e4632b, 32'h0010_0000
  };

  // idx-th most significant nonzero digit of the canonical signed digit form
  function automatic csdTerm_t csdTerm(input logic [COEF_W-1:0] c, input int idx);
    logic signed [COEF_W+3:0] x;
    int digit [COEF_W+2];
    int seen;
    csdTerm_t t;
    x = {4'b0000, c};
    for (int p = 0; p < COEF_W + 2; p++) begin
      if (x[0]) begin
        if (x[1]) begin
          digit[p] = -1;
          x = x + 1;
        end else begin
          digit[p] = 1;
          x = x - 1;
        end
      end else begin
        digit[p] = 0;
      end
      x = x >>> 1;
    end
    t = '0;
    seen = 0;
    for (int p = COEF_W + 1; p >= 0; p--) begin
      if (digit[p] != 0) begin
        if (seen == idx) begin
          t.en  = 1'b1;
          t.neg = (digit[p] < 0);
          t.sh  = 6'(COEF_W - p);
        end
        seen++;
      end
    end
    return t;
  endfunction

  // magnitude of a feedback weight applied to full scale
  function automatic longint fbLevel(input logic [COEF_W-1:0] a, input int fsLog2);
    logic [63:0] wide;
    wide = 64'(a) << fsLog2;
    return longint'(wide >> COEF_W);
  endfunction

endpackage

// File: rtl/sdm_sat_tree.sv
module sdm_sat_tree
  import sdm_crfb6_pkg::*;
#(
  parameter int SW = 32
) (
  input  logic signed [SW:0]   leaf [TREE_LEAVES],
  output logic signed [SW-1:0] sum,
  output logic                 clip
);

  localparam int AW = SW + 1 + TREE_LEVELS;
  localparam logic signed [AW-1:0] MAXV = AW'((longint'(1) <<< (SW - 1)) - 1);
  localparam logic signed [AW-1:0] MINV = -AW'(longint'(1) <<< (SW - 1));

  logic signed [AW-1:0] total;

  // balanced pairwise reduction, TREE_LEVELS adder levels deep
  always_comb begin
    logic signed [AW-1:0] acc [TREE_LEAVES];
    for (int i = 0; i < TREE_LEAVES; i++) acc[i] = AW'(leaf[i]);
    for (int lvl = 0; lvl < TREE_LEVELS; lvl++) begin
      for (int i = 0; i < (TREE_LEAVES >> (lvl + 1)); i++) begin
        acc[i] = acc[2*i] + acc[2*i+1];
      end
    end
    total = acc[0];
  end

  always_comb begin
    clip = 1'b0;
    if (total > MAXV) begin
      sum  = MAXV[SW-1:0];
      clip = 1'b1;
    end else if (total < MINV) begin
      sum  = MINV[SW-1:0];
      clip = 1'b1;
    end else begin
      sum = total[SW-1:0];
    end
  end

endmodule

// File: rtl/sdm_ctrl.sv
module sdm_ctrl
  import sdm_crfb6_pkg::*;
#(
  parameter int IN_W = 32,
  parameter int SW   = 32,
  parameter int HEAD = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ce,
  input  logic [IN_W-1:0]      sampleIn,
  input  logic                 sampleValid,
  output sdmStrobe_t           strobe,
  output logic signed [SW-1:0] xAligned
);

  localparam int LSH = SW - HEAD - SAMPLE_W;

  logic signed [SAMPLE_W-1:0] xHold;
  logic signed [SAMPLE_W-1:0] xTop;
  logic signed [SW-1:0]       xExt;

  generate
    if (IN_W >= SAMPLE_W) begin : gTrim
      assign xTop = sampleIn[IN_W-1 -: SAMPLE_W];
    end else begin : gPad
      assign xTop = {sampleIn, {(SAMPLE_W-IN_W){1'b0}}};
    end
    if (LSH < 0) begin : gBadHead
      $error("SW-HEAD must be at least the internal sample width");
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) xHold <= '0;
    else if (sampleValid) xHold <= xTop;
  end

  assign xExt     = SW'(xHold);
  assign xAligned = xExt <<< LSH;

  assign strobe.update = ce;
  assign strobe.clear  = rst;

endmodule

// File: rtl/sdm_datapath.sv
module sdm_datapath
  import sdm_crfb6_pkg::*;
#(
  parameter int SW   = 32,
  parameter int HEAD = 4,
  parameter int NG   = 4,
  parameter int NB   = 2,
  parameter logic [ORDER-1:0][COEF_W-1:0] FB_COEF = DEF_FB,
  parameter logic [COEF_W-1:0]            IN_COEF = DEF_IN,
  parameter logic [PAIRS-1:0][COEF_W-1:0] G_COEF  = DEF_G
) (
  input  logic                 clk,
  input  sdmStrobe_t           strobe,
  input  logic signed [SW-1:0] xAligned,
  output logic                 bitOut,
  output logic                 ovfFlag
);

  localparam int FS_LOG2  = SW - 1 - HEAD;
  localparam int G_BASE   = 2;
  localparam int IN_BASE  = G_BASE + NG;
  localparam int CHAIN_AT = G_BASE + NG;

  logic signed [SW-1:0] st     [ORDER];
  logic signed [SW-1:0] stNext [ORDER];
  logic [ORDER-1:0]     clip;
  logic                 fbBit;

  assign fbBit  = ~st[ORDER-1][SW-1];
  assign bitOut = fbBit;

  generate
    if (IN_BASE + NB > TREE_LEAVES) begin : gTooWide
      $error("signed-digit terms exceed the adder tree width");
    end

    for (genvar k = 0; k < PAIRS; k++) begin : gPair
      localparam logic signed [SW:0] FBA = (SW+1)'(fbLevel(FB_COEF[2*k], FS_LOG2));
      localparam logic signed [SW:0] FBB = (SW+1)'(fbLevel(FB_COEF[2*k+1], FS_LOG2));

      logic signed [SW:0] leafA [TREE_LEAVES];
      logic signed [SW:0] leafB [TREE_LEAVES];

      for (genvar j = 0; j < TREE_LEAVES; j++) begin : gLeafA
        if (j == 0) begin : gSelf
          assign leafA[j] = (SW+1)'(st[2*k]);
        end else if (j == 1) begin : gFb
          assign leafA[j] = fbBit ? -FBA : FBA;
        end else if (j < G_BASE + NG) begin : gRes
          localparam csdTerm_t T = csdTerm(G_COEF[k], j - G_BASE);
          if (T.en) begin : gOn
            // local resonator feedback is subtracted
            assign leafA[j] = T.neg ? (SW+1)'(st[2*k+1] >>> T.sh)
                                    : -(SW+1)'(st[2*k+1] >>> T.sh);
          end else begin : gOff
            assign leafA[j] = '0;
          end
        end else if (k == 0 && j < IN_BASE + NB) begin : gIn
          localparam csdTerm_t T = csdTerm(IN_COEF, j - IN_BASE);
          if (T.en) begin : gOn
            assign leafA[j] = T.neg ? -(SW+1)'(xAligned >>> T.sh)
                                    : (SW+1)'(xAligned >>> T.sh);
          end else begin : gOff
            assign leafA[j] = '0;
          end
        end else if (k > 0 && j == CHAIN_AT) begin : gChain
          assign leafA[j] = (SW+1)'(st[2*k-1]);
        end else begin : gZero
          assign leafA[j] = '0;
        end
      end

      for (genvar j = 0; j < TREE_LEAVES; j++) begin : gLeafB
        if (j == 0) begin : gSelf
          assign leafB[j] = (SW+1)'(st[2*k+1]);
        end else if (j == 1) begin : gPrev
          assign leafB[j] = (SW+1)'(st[2*k]);
        end else if (j == 2) begin : gFb
          assign leafB[j] = fbBit ? -FBB : FBB;
        end else begin : gZero
          assign leafB[j] = '0;
        end
      end

      sdm_sat_tree #(.SW(SW)) uTreeA (
        .leaf (leafA),
        .sum  (stNext[2*k]),
        .clip (clip[2*k])
      );

      sdm_sat_tree #(.SW(SW)) uTreeB (
        .leaf (leafB),
        .sum  (stNext[2*k+1]),
        .clip (clip[2*k+1])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (strobe.clear) begin
      for (int i = 0; i < ORDER; i++) st[i] <= '0;
      ovfFlag <= 1'b0;
    end else if (strobe.update) begin
      for (int i = 0; i < ORDER; i++) st[i] <= stNext[i];
      ovfFlag <= ovfFlag | (|clip);
    end
  end

endmodule

// File: rtl/sdm_crfb6.sv
module sdm_crfb6
  import sdm_crfb6_pkg::*;
#(
  parameter int IN_W = 32,
  parameter int SW   = 32,
  parameter int HEAD = 4,
  parameter int NG   = 4,
  parameter int NB   = 2,
  parameter logic [ORDER-1:0][COEF_W-1:0] FB_COEF = DEF_FB,
  parameter logic [COEF_W-1:0]            IN_COEF = DEF_IN,
  parameter logic [PAIRS-1:0][COEF_W-1:0] G_COEF  = DEF_G
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ce,
  input  logic [IN_W-1:0] sampleIn,
  input  logic            sampleValid,
  output logic            bitOut,
  output logic            ovfFlag
);

  sdmStrobe_t           strobe;
  logic signed [SW-1:0] xAligned;

  sdm_ctrl #(
    .IN_W (IN_W),
    .SW   (SW),
    .HEAD (HEAD)
  ) uCtrl (
    .clk         (clk),
    .rst         (rst),
    .ce          (ce),
    .sampleIn    (sampleIn),
    .sampleValid (sampleValid),
    .strobe      (strobe),
    .xAligned    (xAligned)
  );

  sdm_datapath #(
    .SW      (SW),
    .HEAD    (HEAD),
    .NG      (NG),
    .NB      (NB),
    .FB_COEF (FB_COEF),
    .IN_COEF (IN_COEF),
    .G_COEF  (G_COEF)
  ) uPath (
    .clk      (clk),
    .strobe   (strobe),
    .xAligned (xAligned),
    .bitOut   (bitOut),
    .ovfFlag  (ovfFlag)
  );

endmodule

// File: rtl/sdm_crfb6_chk.sv
module sdm_crfb6_chk (
  input logic clk,
  input logic rst,
  input logic ce,
  input logic bitOut,
  input logic ovfFlag
);

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (bitOut && !ovfFlag)); // R1

  AST_HOLD_BIT: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(bitOut)); // R2

  AST_HOLD_FLAG: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(ovfFlag)); // R2

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    ovfFlag |=> ovfFlag); // R10

  AST_FLAG_ON_UPDATE: assert property (@(posedge clk) disable iff (rst)
    $rose(ovfFlag) |-> $past(ce)); // R10

endmodule

bind sdm_crfb6 sdm_crfb6_chk uChk (
  .clk     (clk),
  .rst     (rst),
  .ce      (ce),
  .bitOut  (bitOut),
  .ovfFlag (ovfFlag)
);

// File: tb/tb_sdm_crfb6.sv
`timescale 1ns/1ps
module tb_sdm_crfb6;

  localparam int IN_W = 32;
  localparam int SW   = 32;
  localparam int HEAD = 4;
  localparam int NG   = 4;
  localparam int NB   = 2;
  localparam int FSL  = SW - 1 - HEAD;
  localparam logic [5:0][31:0] FBC = {
    32'h4000_0000, 32'h2000_0000, 32'h1000_0000,
    32'h0800_0000, 32'h0400_0000, 32'h4000_0000
  };
  localparam logic [31:0]      INC = 32'h4000_0000;
  localparam logic [2:0][31:0] GC  = {32'h0040_0000, 32'h16e4632b, 32'h0010_0000};

  // {sample, cycles, ce stride}
  localparam logic [51:0] VEC [8] = '{
    {32'h0000_0000, 16'd200, 4'd1},
    {32'h2000_0000, 16'd300, 4'd1},
    {32'hE000_0000, 16'd300, 4'd1},
    {32'h0123_4567, 16'd200, 4'd3},
    {32'hFFFF_FF00, 16'd150, 4'd1},
    {32'h4000_00AB, 16'd250, 4'd2},
    {32'hC000_0000, 16'd250, 4'd1},
    {32'h0800_0000, 16'd300, 4'd4}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce = 1'b0;
  logic sampleValid = 1'b0;
  logic [IN_W-1:0] sampleIn = '0;
  logic bitOut, ovfFlag;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  longint mSt [6];
  longint mX;
  bit     mOvf;

  always #2 clk = ~clk;

  sdm_crfb6 #(
    .IN_W(IN_W), .SW(SW), .HEAD(HEAD), .NG(NG), .NB(NB),
    .FB_COEF(FBC), .IN_COEF(INC), .G_COEF(GC)
  ) dut (
    .clk(clk), .rst(rst), .ce(ce), .sampleIn(sampleIn),
    .sampleValid(sampleValid), .bitOut(bitOut), .ovfFlag(ovfFlag)
  );

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: cycles=%0d expected below 150000", cycles);
      finishRun();
    end
  end

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // signed-digit product, top n nonzero digits of c (R7)
  function automatic longint csdProd(input logic [31:0] c, input int n, input longint s);
    longint r, sum;
    int d [34];
    int used;
    r = longint'(c);
    for (int p = 0; p < 34; p++) begin
      if (r % 2 != 0) begin
        d[p] = 2 - int'(r % 4);
        r = r - d[p];
      end else d[p] = 0;
      r = r / 2;
    end
    sum = 0;
    used = 0;
    for (int p = 33; p >= 0; p--) begin
      if (d[p] != 0 && used < n) begin
        sum += (d[p] > 0) ? (s >>> (32 - p)) : -(s >>> (32 - p));
        used++;
      end
    end
    return sum;
  endfunction

  function automatic longint sat(input longint v, inout bit hit);
    longint hi, lo;
    hi = (longint'(1) << (SW - 1)) - 1;
    lo = -(longint'(1) << (SW - 1));
    if (v > hi) begin hit = 1'b1; return hi; end
    if (v < lo) begin hit = 1'b1; return lo; end
    return v;
  endfunction

  function automatic longint align(input logic [31:0] s);
    logic signed [23:0] top;
    top = s[31:8];
    return longint'(top) * (longint'(1) << (SW - HEAD - 24));
  endfunction

  function automatic bit mBit();
    return mSt[5] >= 0;
  endfunction

  function automatic void modelStep();
    longint n [6];
    longint lv;
    bit hit;
    bit b;
    b = mBit();
    hit = 1'b0;
    for (int k = 0; k < 3; k++) begin
      lv = longint'((64'(FBC[2*k]) << FSL) >> 32);
      n[2*k] = mSt[2*k] + (b ? -lv : lv) - csdProd(GC[k], NG, mSt[2*k+1])
             + ((k == 0) ? csdProd(INC, NB, mX) : mSt[2*k-1]);
      lv = longint'((64'(FBC[2*k+1]) << FSL) >> 32);
      n[2*k+1] = mSt[2*k+1] + mSt[2*k] + (b ? -lv : lv);
    end
    for (int i = 0; i < 6; i++) mSt[i] = sat(n[i], hit);
    mOvf = mOvf | hit;
  endfunction

  task automatic doReset();
    rst = 1'b1; ce = 1'b0; sampleValid = 1'b0;
    @(posedge clk);
    @(posedge clk);
    for (int i = 0; i < 6; i++) mSt[i] = 0;
    mX = 0;
    mOvf = 1'b0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  // one clock: drive at negedge, model at posedge, sample at next negedge
  task automatic cyc(input bit c, input bit v, input logic [31:0] s);
    ce = c; sampleValid = v; sampleIn = s;
    @(posedge clk);
    if (c) modelStep();
    if (v) mX = align(s);
    @(negedge clk);
    ce = 1'b0; sampleValid = 1'b0;
  endtask

  task automatic cmp(input string tag);
    check({tag, " bitOut"}, longint'(bitOut), longint'(mBit()));
    check({tag, " ovfFlag"}, longint'(ovfFlag), longint'(mOvf));
  endtask

  bit streamA [256];
  bit heldBit, heldOvf;

  initial begin
    doReset();
    // R1: reset state
    check("R1 reset bitOut", longint'(bitOut), 1);
    check("R1 reset ovfFlag", longint'(ovfFlag), 0);

    // table-driven runs: R5 R6 R7 R8 against the model
    for (int v = 0; v < 8; v++) begin
      logic [31:0] smp;
      int nCyc, stride;
      smp = VEC[v][51:20];
      nCyc = int'(VEC[v][19:4]);
      stride = int'(VEC[v][3:0]);
      cyc(1'b1, 1'b1, smp);
      cmp("R6 load");
      for (int i = 1; i < nCyc; i++) begin
        cyc((i % stride) == 0, 1'b0, smp);
        cmp("R7 R8 stream");
      end
    end

    // R2: no update while ce is low, even when samples load
    doReset();
    for (int i = 0; i < 37; i++) cyc(1'b1, (i == 0), 32'h3000_0000);
    heldBit = bitOut;
    heldOvf = ovfFlag;
    for (int i = 0; i < 20; i++) begin
      cyc(1'b0, 1'b1, 32'h8000_0000 + 32'(i * 32'h0111_1111));
      check("R2 hold bitOut", longint'(bitOut), longint'(heldBit));
      check("R2 hold ovfFlag", longint'(ovfFlag), longint'(heldOvf));
    end
    for (int i = 0; i < 40; i++) begin
      cyc(1'b1, 1'b0, 32'h0);
      cmp("R2 resume");
    end

    // R4: load and update in the same edge use the old sample
    doReset();
    cyc(1'b1, 1'b1, 32'h5000_0000);
    cyc(1'b1, 1'b1, 32'hB000_0000);
    for (int i = 0; i < 60; i++) begin
      cyc(1'b1, (i % 7) == 0, 32'h1000_0000 + 32'(i << 20));
      cmp("R4 ordering");
    end

    // R3: low input bits ignored
    doReset();
    cyc(1'b1, 1'b1, 32'h1234_5600);
    for (int i = 0; i < 256; i++) begin
      cyc(1'b1, 1'b0, 32'h0);
      streamA[i] = bitOut;
    end
    doReset();
    cyc(1'b1, 1'b1, 32'h1234_56FF);
    for (int i = 0; i < 256; i++) begin
      cyc(1'b1, 1'b0, 32'h0);
      cmp("R3 model");
      if (i % 32 == 0) check("R3 low bits ignored", longint'(bitOut), longint'(streamA[i]));
    end

    // R9 R10: sustained full scale drives the clamps
    doReset();
    cyc(1'b1, 1'b1, 32'h7FFF_FF00);
    for (int i = 0; i < 4000; i++) begin
      cyc(1'b1, 1'b0, 32'h0);
      cmp("R9 saturation");
    end
    if (mOvf) begin
      cyc(1'b1, 1'b1, 32'h0);
      for (int i = 0; i < 50; i++) begin
        cyc(1'b1, 1'b0, 32'h0);
        check("R10 sticky", longint'(ovfFlag), 1);
      end
    end
    doReset();
    check("R10 cleared by reset", longint'(ovfFlag), 0);
    check("R1 bitOut after second reset", longint'(bitOut), 1);

    finishRun();
  end

endmodule